// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous request source and an external asynchronous static RAM. The RAM has 18 address bits and a 16-bit data path split into two byte lanes. The controller accepts one access at a time on a valid/ready request port. It then runs the memory's active-low strobes (chip select, write strobe, output enable and one enable per byte lane) through timed phases. Read data comes back on a response strobe. The external bus is tri-state, so the pad drive is split into an output value, an output enable and an input value.

Every phase length is a number of clock cycles derived from nanosecond parameters and the clock period. Each count is the ceiling of time over period, and any nonzero time needs at least one cycle. After reset the controller waits out the memory's power-up interval with every strobe inactive and ready low. Between accesses it holds the chip deselected, which keeps the memory in standby.

A write is the overlap of chip select, write strobe and the chosen lane enables. All of them are released on one clock edge, and that same edge also releases the data drive. The write-to-read and read-to-write turnarounds use idle cycles so that the controller and the memory never drive the bus at the same time.

Back-pressure rules: a request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the transfer until the access and its recovery phase have finished. The request fields are registered when the transfer happens. The response has no ready: `rsp_valid` is a one-cycle pulse, and the requester must take the data in that cycle.

Top module: `sram_byte_ctrl`

## Requirements
- R1: After reset is released, `req_ready` stays low for N_PWR = ceil(T_PWR_NS/CLK_NS) rising edges, and `req_ready` rises at edge N_PWR. Throughout that time chip select, write strobe and output enable are high and the data drive is off.
- R2: While idle (`req_ready` high), chip select, write strobe, output enable and all lane enables are high and the data drive is off.
- R3: A write holds chip select and write strobe low for N_WE cycles, where N_WE is the maximum of ceil(35/10), ceil(40/10) and ceil(25/10), which is 4 at the defaults. During those cycles output enable is high and the address stays stable. Lane enable `sram_be_n[i]` is low exactly when mask bit i is 1 (bit 0 is data bits 7:0, bit 1 is data bits 15:8).
- R4: The data drive is on exactly while the write strobe is low, and the driven value is the write data of the accepted request.
- R5: Chip select, write strobe, lane enables and the data drive all go inactive on the same edge. They then stay inactive for N_WREC = max(1, ceil(T_WC_NS/CLK_NS) - N_WE) cycles, which guarantees at least one idle cycle before any read. After that, `req_ready` returns.
- R6: A read holds chip select and output enable low, the write strobe high and the data drive off for N_RD = max(ceil(T_AA_NS/CLK_NS), ceil(T_DOE_NS/CLK_NS)) cycles. The lane enables follow the mask as in R3.
- R7: Read data is sampled on the edge that ends the read phase. `rsp_valid` is high for exactly the one following cycle, and unselected lanes read as zero.
- R8: After a read, all strobes stay inactive for N_RREC = max(ceil(T_OHZ_NS/CLK_NS), ceil(T_RC_NS/CLK_NS) - N_RD, 1) cycles (2 at the defaults) before `req_ready` returns.
- R9: Cycle counts are ceil(time/period) and are never zero for a nonzero time. The phase lengths in R3, R5, R6 and R8 match this rule at the default parameters.
- R10: A request transfers only when valid and ready are both high. Changing the request fields while busy has no effect on `sram_addr`, `sram_dq_out` or the lane enables.
- R11: A mask of 0 runs the full access timing with both lane enables high. A write then leaves memory unchanged, and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (18) | Word address |
| req_wdata | input | DW (16) | Write data |
| req_bmask | input | DW/8 (2) | Lane select, bit i = byte i |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DW (16) | Read data, unselected lanes zero |
| sram_addr | output | AW (18) | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_be_n | output | DW/8 (2) | Lane enables, active low |
| sram_dq_out | output | DW (16) | Value driven onto the data bus |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dq_in | input | DW (16) | Value sampled from the data bus |

## Verification
The assertions assume that `rst_n` is low for at least one clock edge. They also assume that the timing parameters yield the default phase counts, so that no phase overlaps. The bench drives inputs only at falling edges and requests only when `req_ready` is high, so every transfer follows the handshake rule. Its memory model returns valid data only after the read strobes have been held for the full access count and returns filler bytes on disabled lanes. Any early capture or lane-masking error therefore shows up in the response.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_WR,
    ST_WREC,
    ST_RD,
    ST_RREC
  } ctrl_st_e;

  // ceiling of time over period; zero time needs zero cycles
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    if (t_ns <= 0) return 0;
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW      = 8,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= CW'(RST_VAL);
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
  import sram_ctrl_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_st_e         nxt_st,
  input  logic [LANES-1:0] lane_en,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic [LANES-1:0] be_n,
  output logic             dq_oe
);

  logic wr_ph, rd_ph;
  assign wr_ph = (nxt_st == ST_WR);
  assign rd_ph = (nxt_st == ST_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      ce_n  <= !(wr_ph || rd_ph);
      we_n  <= !wr_ph;
      oe_n  <= !rd_ph;
      dq_oe <= wr_ph;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) be_n[g] <= 1'b1;
      else        be_n[g] <= !((wr_ph || rd_ph) && lane_en[g]);
    end
  end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DW = 16,
  localparam int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [LANES-1:0] lane_en,
  input  logic [DW-1:0]    dq_in,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= cap_en;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rsp_rdata[g*8 +: 8] <= 8'h00;
      else if (cap_en)
        rsp_rdata[g*8 +: 8] <= lane_en[g] ? dq_in[g*8 +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 18,
  parameter int DW        = 16,
  parameter int CLK_NS    = 10,
  parameter int T_PWR_NS  = 200000,
  parameter int T_WP_NS   = 35,
  parameter int T_AW_NS   = 40,
  parameter int T_SD_NS   = 25,
  parameter int T_WC_NS   = 45,
  parameter int T_AA_NS   = 45,
  parameter int T_DOE_NS  = 25,
  parameter int T_RC_NS   = 45,
  parameter int T_OHZ_NS  = 15,
  localparam int LANES    = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_bmask,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic [AW-1:0]    sram_addr,
  output logic             sram_ce_n,
  output logic             sram_we_n,
  output logic             sram_oe_n,
  output logic [LANES-1:0] sram_be_n,
  output logic [DW-1:0]    sram_dq_out,
  output logic             sram_dq_oe,
  input  logic [DW-1:0]    sram_dq_in
);

  localparam int N_PWR  = imax(1, ns_to_cyc(T_PWR_NS, CLK_NS));
  localparam int N_WE   = imax(1, imax(ns_to_cyc(T_WP_NS, CLK_NS),
                                  imax(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS))));
  localparam int N_WREC = imax(1, ns_to_cyc(T_WC_NS, CLK_NS) - N_WE);
  localparam int N_RD   = imax(1, imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS)));
  localparam int N_RREC = imax(1, imax(ns_to_cyc(T_OHZ_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS) - N_RD));
  localparam int N_MAX  = imax(N_PWR, imax(imax(N_WE, N_WREC), imax(N_RD, N_RREC)));
  localparam int CW     = $clog2(N_MAX + 1);

  ctrl_st_e st_q, st_d;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [LANES-1:0] mask_q, lane_nxt;
  logic             accept, tmr_load, tmr_done, cap_en;
  logic [CW-1:0]    tmr_val;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign lane_nxt  = accept ? req_bmask : mask_q;

  // request fields are held from transfer to the end of the access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_bmask;
    end
  end

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap_en   = 1'b0;
    unique case (st_q)
      ST_PWRUP: if (tmr_done) st_d = ST_IDLE;
      ST_IDLE: begin
        if (accept) begin
          tmr_load = 1'b1;
          if (req_write) begin
            st_d    = ST_WR;
            tmr_val = CW'(N_WE - 1);
          end else begin
            st_d    = ST_RD;
            tmr_val = CW'(N_RD - 1);
          end
        end
      end
      ST_WR: begin
        if (tmr_done) begin
          st_d     = ST_WREC;
          tmr_load = 1'b1;
          tmr_val  = CW'(N_WREC - 1);
        end
      end
      ST_WREC: if (tmr_done) st_d = ST_IDLE;
      ST_RD: begin
        if (tmr_done) begin
          st_d     = ST_RREC;
          tmr_load = 1'b1;
          tmr_val  = CW'(N_RREC - 1);
          cap_en   = 1'b1;
        end
      end
      ST_RREC: if (tmr_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_PWRUP;
    else        st_q <= st_d;
  end

  sram_phase_timer #(.CW(CW), .RST_VAL(N_PWR - 1)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_strobe_gen #(.LANES(LANES)) u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .nxt_st  (st_d),
    .lane_en (lane_nxt),
    .ce_n    (sram_ce_n),
    .we_n    (sram_we_n),
    .oe_n    (sram_oe_n),
    .be_n    (sram_be_n),
    .dq_oe   (sram_dq_oe)
  );

  sram_rd_capture #(.DW(DW)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .lane_en   (mask_q),
    .dq_in     (sram_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign sram_addr   = addr_q;
  assign sram_dq_out = wdata_q;

endmodule

// File: rtl/sram_byte_ctrl_chk.sv
module sram_byte_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int CLK_NS   = 10,
  parameter int T_PWR_NS = 200000,
  localparam int LANES   = DW / 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [AW-1:0]    sram_addr,
  input logic             sram_ce_n,
  input logic             sram_we_n,
  input logic             sram_oe_n,
  input logic [LANES-1:0] sram_be_n,
  input logic             sram_dq_oe
);

  localparam int N_PWR = imax(1, ns_to_cyc(T_PWR_NS, CLK_NS));
  localparam int PCW   = $clog2(N_PWR + 1);

  logic [PCW-1:0] pwr_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pwr_cnt <= '0;
    else if (pwr_cnt != PCW'(N_PWR))  pwr_cnt <= pwr_cnt + 1'b1;
  end

  p_pwrup_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_cnt < PCW'(N_PWR)) |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe && !req_ready));

  p_idle_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe && (&sram_be_n)));

  p_we_with_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce_n && sram_oe_n));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_addr));

  p_drive_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe == !sram_we_n);

  p_write_end_together_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (sram_ce_n && (&sram_be_n) && !sram_dq_oe));

  p_gap_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sram_we_n) |-> sram_oe_n);

  p_no_contend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (!sram_dq_oe && sram_we_n && !sram_ce_n));

  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!sram_oe_n));

  p_busy_no_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> !req_ready);

endmodule

bind sram_byte_ctrl sram_byte_ctrl_chk #(
  .AW(AW), .DW(DW), .CLK_NS(CLK_NS), .T_PWR_NS(T_PWR_NS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .sram_addr  (sram_addr),
  .sram_ce_n  (sram_ce_n),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_be_n  (sram_be_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/tb_sram_byte_ctrl.sv
module tb_sram_byte_ctrl;

  localparam int CLK_PERIOD = 10;

  function automatic int cdiv(input int t, input int p);
    return (t + p - 1) / p;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int NPWR  = cdiv(200000, CLK_PERIOD);
  localparam int NWE   = mx(cdiv(35, CLK_PERIOD), mx(cdiv(40, CLK_PERIOD), cdiv(25, CLK_PERIOD)));
  localparam int NWREC = mx(1, cdiv(45, CLK_PERIOD) - NWE);
  localparam int NRD   = mx(cdiv(45, CLK_PERIOD), cdiv(25, CLK_PERIOD));
  localparam int NRREC = mx(1, mx(cdiv(15, CLK_PERIOD), cdiv(45, CLK_PERIOD) - NRD));

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_bmask = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] sram_addr;
  logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [1:0]  sram_be_n;
  logic [15:0] sram_dq_out;
  logic [15:0] model_q = 16'hDEAD;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_byte_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_be_n(sram_be_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(model_q)
  );

  // memory model: commits when the write overlap ends, drives after the access time
  logic [15:0] mem [int];
  logic [15:0] shadow [int];
  bit          p_wr = 1'b0;
  logic [17:0] p_addr = '0;
  logic [1:0]  p_be = 2'b11;
  logic [15:0] p_d = '0;
  int          rd_cnt = 0;

  function automatic logic [15:0] mem_rd(input logic [17:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    bit wr_now, rd_now;
    logic [15:0] w;
    wr_now = !sram_ce_n && !sram_we_n && (sram_be_n != 2'b11);
    rd_now = !sram_ce_n && !sram_oe_n && sram_we_n;
    if (p_wr && !wr_now) begin
      w = mem_rd(p_addr);
      if (!p_be[0]) w[7:0]  = p_d[7:0];
      if (!p_be[1]) w[15:8] = p_d[15:8];
      mem[int'(p_addr)] = w;
    end
    p_wr = wr_now; p_addr = sram_addr; p_be = sram_be_n; p_d = sram_dq_out;
    rd_cnt = rd_now ? rd_cnt + 1 : 0;
    if (rd_now && rd_cnt >= NRD) begin
      w = mem_rd(sram_addr);
      model_q[7:0]  = !sram_be_n[0] ? w[7:0]  : 8'h5A;
      model_q[15:8] = !sram_be_n[1] ? w[15:8] : 8'h5A;
    end else begin
      model_q = 16'hDEAD;
    end
    if (sram_dq_oe && rd_now) begin
      n_tests++; n_fail++;
      $display("FAIL R6 bus contention act=1 exp=0");
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [17:0] a, input logic [1:0] m);
    logic [15:0] w;
    w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
  endfunction

  function automatic bit all_idle();
    return sram_ce_n && sram_we_n && sram_oe_n && (sram_be_n == 2'b11) && !sram_dq_oe;
  endfunction

  // starts and ends on a falling edge with req_ready high
  task automatic do_wr(input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    int g_str = 0, g_bus = 0, g_hold = 0, g_idle = 0;
    logic [15:0] w;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_bmask = m;
    for (int i = 0; i < NWE; i++) begin
      @(negedge clk);
      if (i == 0) begin
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_bmask = ~m;
      end
      if (!sram_ce_n && !sram_we_n && sram_oe_n && (sram_be_n == ~m) && !req_ready) g_str++;
      if (sram_dq_oe && sram_dq_out == d) g_bus++;
      if (sram_addr == a) g_hold++;
    end
    chk("R3 R9 write strobe cycles", g_str, NWE);
    chk("R4 data driven during write strobe", g_bus, NWE);
    chk("R10 address held while busy", g_hold, NWE);
    for (int i = 0; i < NWREC; i++) begin
      @(negedge clk);
      if (all_idle() && !req_ready) g_idle++;
    end
    chk("R5 write recovery idle cycles", g_idle, NWREC);
    @(negedge clk);
    chk("R5 ready after write", req_ready, 1);
    w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    if (m[0]) w[7:0]  = d[7:0];
    if (m[1]) w[15:8] = d[15:8];
    shadow[int'(a)] = w;
  endtask

  task automatic do_rd(input logic [17:0] a, input logic [1:0] m);
    int g_str = 0, g_rec = 0;
    logic [15:0] e;
    e = exp_rd(a, m);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_bmask = m;
    for (int i = 0; i < NRD; i++) begin
      @(negedge clk);
      if (i == 0) begin req_valid = 1'b0; req_addr = ~a; req_bmask = ~m; end
      if (!sram_ce_n && !sram_oe_n && sram_we_n && !sram_dq_oe && (sram_be_n == ~m)
          && !rsp_valid && sram_addr == a) g_str++;
    end
    chk("R6 R9 read strobe cycles", g_str, NRD);
    @(negedge clk);
    chk("R7 response strobe", rsp_valid, 1);
    chk("R7 read data", rsp_rdata, e);
    if (all_idle() && !req_ready) g_rec++;
    for (int i = 1; i < NRREC; i++) begin
      @(negedge clk);
      if (all_idle() && !req_ready && !rsp_valid) g_rec++;
    end
    chk("R8 read recovery idle cycles", g_rec, NRREC);
    @(negedge clk);
    chk("R8 ready after read", req_ready, 1);
    chk("R7 strobe lasts one cycle", rsp_valid, 0);
  endtask

  task automatic t_powerup();
    int g_q = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready low", req_ready, 0);
    chk("R1 reset strobes inactive", all_idle(), 1);
    rst_n = 1'b1;
    for (int i = 1; i < NPWR; i++) begin
      @(negedge clk);
      if (!req_ready && all_idle()) g_q++;
    end
    chk("R1 quiet during power-up wait", g_q, NPWR - 1);
    @(negedge clk);
    chk("R1 ready at end of wait", req_ready, 1);
    chk("R2 idle deselected", all_idle(), 1);
  endtask

  task automatic t_idle_hold();
    int g = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (all_idle() && req_ready) g++;
    end
    chk("R2 idle stays deselected", g, 5);
  endtask

  task automatic t_full_word();
    do_wr(18'h00010, 16'hA1B2, 2'b11);
    do_rd(18'h00010, 2'b11);
  endtask

  task automatic t_lanes();
    do_wr(18'h3FFFF, 16'h1234, 2'b11);
    do_wr(18'h3FFFF, 16'hCC77, 2'b01);
    do_rd(18'h3FFFF, 2'b11);
    do_wr(18'h3FFFF, 16'h99EE, 2'b10);
    do_rd(18'h3FFFF, 2'b11);
    do_rd(18'h3FFFF, 2'b01);
    do_rd(18'h3FFFF, 2'b10);
  endtask

  task automatic t_turnaround();
    do_wr(18'h00ABC, 16'h5555, 2'b11);
    do_rd(18'h00ABC, 2'b11);
    do_wr(18'h00ABD, 16'hAAAA, 2'b11);
    do_rd(18'h00ABD, 2'b11);
  endtask

  task automatic t_mask_zero();
    do_wr(18'h00200, 16'h0F0F, 2'b11);
    do_wr(18'h00200, 16'hFFFF, 2'b00);
    do_rd(18'h00200, 2'b11);
    chk("R11 masked write left memory", mem_rd(18'h00200), 16'h0F0F);
    do_rd(18'h00200, 2'b00);
  endtask

  initial begin
    t_powerup();
    t_idle_hold();
    t_full_word();
    t_lanes();
    t_turnaround();
    t_mask_zero();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule